// File: doc/BRIEF.md
# Scatter-Gather Copy Engine

This engine moves blocks of data from card-local memory into host memory by following a list of transfer descriptors. The descriptors sit back to back in memory. Software writes the address of the first descriptor into a base register and pulses a start input. The engine then reads each descriptor over a word-wide fetch port. For each element it copies the described byte span one 32-bit word at a time: it reads the word on a source port and writes it unchanged on a destination port.

Each descriptor holds three words: a source address, a destination address and a control word. The control word carries the byte count and a last-element flag. When the last element finishes, or when an error cuts the run short, the engine raises a one-cycle done interrupt. A five-bit sticky status register records the outcome. Software clears the status bits by writing ones to them.

Top module: `sg_copy_engine`

## Requirements
- R1: A descriptor is three consecutive words, fetched in order from base+0, base+4 and base+8: the source address, then the destination address, then the control word.
- R2: Bits 17:0 of the control word give the element's byte count. Bits 30:18 are reserved and have no effect on the transfer.
- R3: A byte count that is zero or is not a whole multiple of 256 sets status bit 4, moves no data for that element, ends the run and raises the done interrupt.
- R4: Word i of an element is read from source+4i and written unchanged to destination+4i. Data is treated as little-endian words, with no byte reordering.
- R5: Control bit 31 marks the last element. After that element completes, the engine goes idle and drives the done interrupt high for exactly one cycle. After any other element, the next descriptor is fetched 12 bytes further on.
- R6: The status register is at register offset 0x4. Bit 0 is set when the final source read of the last element completes. Bit 1 is set when the final destination write of the last element is acknowledged.
- R7: An error response on the source port sets status bit 2, skips the write of that word, abandons the remaining elements and raises the done interrupt.
- R8: An error response on the destination port sets status bit 3, abandons the remaining elements and raises the done interrupt.
- R9: Writing a one to a status bit clears it. Writing a zero leaves the bit as it is. A bit that is set stays set until it is cleared.
- R10: A start pulse that arrives while the engine is busy is ignored.
- R11: After reset the engine is idle: no request is active, the done interrupt is low and the status register reads zero.
- R12: At most one of the three memory ports requests at a time. A request, with its address and write data, is held steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; begins walking the descriptors from the base address |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register byte offset (0x0 base, 0x4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| busy | output | 1 | High while a run is in progress |
| irq_done | output | 1 | One-cycle done interrupt |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | 32 | Descriptor word address |
| desc_ack | input | 1 | Descriptor fetch acknowledge |
| desc_rdata | input | 32 | Descriptor word |
| src_req | output | 1 | Source read request |
| src_addr | output | 32 | Source word address |
| src_ack | input | 1 | Source read acknowledge |
| src_err | input | 1 | Source error response, valid with src_ack |
| src_rdata | input | 32 | Source read data |
| dst_req | output | 1 | Destination write request |
| dst_addr | output | 32 | Destination word address |
| dst_wdata | output | 32 | Destination write data |
| dst_ack | input | 1 | Destination write acknowledge |
| dst_err | input | 1 | Destination error response, valid with dst_ack |

## Verification
The assertions check the port rules on every cycle: only one request is active at a time, and a request stays stable until it is acknowledged. They also check that a bad count or a source error leads straight to the finish state with the matching status bit set, that the done pulse leaves the engine idle, and that status bits stay set until cleared. The scenarios check the rest. These cover the data and addresses of each word across single and chained elements, the order of descriptor fetches, the final status value of each kind of run, the clear-by-writing-one behaviour, a start pulse ignored mid-run, and runs where reserved control bits are set.

// File: rtl/sg_copy_pkg.sv
package sg_copy_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } sg_state_e;

    localparam int STAT_W     = 5;
    localparam int SB_RD_DONE = 0;
    localparam int SB_WR_DONE = 1;
    localparam int SB_RD_ERR  = 2;
    localparam int SB_WR_ERR  = 3;
    localparam int SB_SG_ERR  = 4;
endpackage

// File: rtl/sg_ctrl_decode.sv
module sg_ctrl_decode #(
    parameter int DW    = 32,
    parameter int CNT_W = 18,
    parameter int GRAN  = 256
) (
    input  logic [DW-1:0]    ctrl,
    output logic [CNT_W-1:0] count,
    output logic             last,
    output logic             count_ok
);
    localparam int GRAN_LSB = $clog2(GRAN);

    always_comb begin
        count    = ctrl[CNT_W-1:0];
        last     = ctrl[DW-1];
        count_ok = (count != '0) && (count[GRAN_LSB-1:0] == '0);
    end
endmodule

// File: rtl/sg_status_reg.sv
module sg_status_reg
    import sg_copy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_bits,
    input  logic [STAT_W-1:0] clr_bits,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] stat_d;

    always_comb begin
        stat_d = (stat_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_sticky
        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !clr_bits[i]) |=> stat_q[i]);
    end
endmodule

// File: rtl/sg_copy_engine.sv
module sg_copy_engine
    import sg_copy_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CNT_W  = 18,
    parameter int GRAN   = 256,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              busy,
    output logic              irq_done,
    output logic              desc_req,
    output logic [AW-1:0]     desc_addr,
    input  logic              desc_ack,
    input  logic [DW-1:0]     desc_rdata,
    output logic              src_req,
    output logic [AW-1:0]     src_addr,
    input  logic              src_ack,
    input  logic              src_err,
    input  logic [DW-1:0]     src_rdata,
    output logic              dst_req,
    output logic [AW-1:0]     dst_addr,
    output logic [DW-1:0]     dst_wdata,
    input  logic              dst_ack,
    input  logic              dst_err
);
    localparam int BPW         = DW / 8;
    localparam int DESC_WORDS  = 3;
    localparam int DESC_STRIDE = DESC_WORDS * BPW;
    localparam logic [REG_AW-1:0] OFS_BASE = REG_AW'(0);
    localparam logic [REG_AW-1:0] OFS_STAT = REG_AW'(4);

    typedef struct packed {
        sg_state_e        st;
        logic [AW-1:0]    base;
        logic [AW-1:0]    ptr;
        logic [1:0]       widx;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [DW-1:0]    ctrl;
        logic [CNT_W-1:0] rem;
        logic [DW-1:0]    data;
    } eng_regs_t;

    eng_regs_t r_q, r_d;
    logic [STAT_W-1:0] set_d, clr_d, stat_q;
    logic [CNT_W-1:0]  cnt_w;
    logic              last_w, cnt_ok_w;
    logic              last_word;

    sg_ctrl_decode #(.DW(DW), .CNT_W(CNT_W), .GRAN(GRAN)) u_dec (
        .ctrl     (r_q.ctrl),
        .count    (cnt_w),
        .last     (last_w),
        .count_ok (cnt_ok_w)
    );

    sg_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_d),
        .clr_bits (clr_d),
        .stat_q   (stat_q)
    );

    always_comb begin
        r_d       = r_q;
        set_d     = '0;
        clr_d     = '0;
        last_word = (r_q.rem == CNT_W'(BPW));

        if (reg_we && reg_addr == OFS_BASE) r_d.base = reg_wdata[AW-1:0];
        if (reg_we && reg_addr == OFS_STAT) clr_d = reg_wdata[STAT_W-1:0];

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.ptr  = r_q.base;
                    r_d.widx = '0;
                    r_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (desc_ack) begin
                    unique case (r_q.widx)
                        2'd0:    r_d.src  = desc_rdata[AW-1:0];
                        2'd1:    r_d.dst  = desc_rdata[AW-1:0];
                        default: r_d.ctrl = desc_rdata;
                    endcase
                    if (r_q.widx == 2'(DESC_WORDS - 1)) r_d.st = ST_CHECK;
                    else                                r_d.widx = r_q.widx + 2'd1;
                end
            end
            ST_CHECK: begin
                if (!cnt_ok_w) begin
                    set_d[SB_SG_ERR] = 1'b1;
                    r_d.st           = ST_FINISH;
                end else begin
                    r_d.rem = cnt_w;
                    r_d.st  = ST_READ;
                end
            end
            ST_READ: begin
                if (src_ack) begin
                    if (src_err) begin
                        set_d[SB_RD_ERR] = 1'b1;
                        r_d.st           = ST_FINISH;
                    end else begin
                        r_d.data = src_rdata;
                        if (last_word && last_w) set_d[SB_RD_DONE] = 1'b1;
                        r_d.st = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (dst_ack) begin
                    if (dst_err) begin
                        set_d[SB_WR_ERR] = 1'b1;
                        r_d.st           = ST_FINISH;
                    end else begin
                        r_d.src = r_q.src + AW'(BPW);
                        r_d.dst = r_q.dst + AW'(BPW);
                        r_d.rem = r_q.rem - CNT_W'(BPW);
                        if (!last_word) begin
                            r_d.st = ST_READ;
                        end else if (last_w) begin
                            set_d[SB_WR_DONE] = 1'b1;
                            r_d.st            = ST_FINISH;
                        end else begin
                            r_d.ptr  = r_q.ptr + AW'(DESC_STRIDE);
                            r_d.widx = '0;
                            r_d.st   = ST_FETCH;
                        end
                    end
                end
            end
            ST_FINISH: r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != ST_IDLE);
        irq_done  = (r_q.st == ST_FINISH);
        desc_req  = (r_q.st == ST_FETCH);
        desc_addr = r_q.ptr + AW'(r_q.widx) * AW'(BPW);
        src_req   = (r_q.st == ST_READ);
        src_addr  = r_q.src;
        dst_req   = (r_q.st == ST_WRITE);
        dst_addr  = r_q.dst;
        dst_wdata = r_q.data;
        if (reg_addr == OFS_BASE)      reg_rdata = DW'(r_q.base);
        else if (reg_addr == OFS_STAT) reg_rdata = DW'(stat_q);
        else                           reg_rdata = '0;
    end

    p_one_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_req, src_req, dst_req}));
    p_src_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_ack) |=> (src_req && $stable(src_addr)));
    p_dst_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_req && !dst_ack) |=> (dst_req && $stable(dst_addr) && $stable(dst_wdata)));
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !busy);
    p_bad_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHECK && !cnt_ok_w) |=> (irq_done && stat_q[SB_SG_ERR]));
    p_src_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && src_ack && src_err) |=> (irq_done && stat_q[SB_RD_ERR]));
    p_dst_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_req && dst_ack && dst_err) |=> (irq_done && stat_q[SB_WR_ERR]));
endmodule

// File: tb/tb_sg_copy_engine.sv
module tb_sg_copy_engine;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DBASE = 32'h40;
    localparam int NT = 5;
    localparam logic [17:0] T_C0  [NT] = '{18'd256, 18'd256, 18'd256, 18'd0,  18'd1024};
    localparam logic [17:0] T_C1  [NT] = '{18'd0,   18'd512, 18'd260, 18'd0,  18'd256};
    localparam bit          T_TWO [NT] = '{1'b0,    1'b1,    1'b1,    1'b0,   1'b1};
    localparam logic [4:0]  T_ST  [NT] = '{5'h03,   5'h03,   5'h10,   5'h10,  5'h03};
    localparam int          T_WR  [NT] = '{64,      192,     64,      0,      320};

    logic clk = 0, rst_n = 0, start = 0, reg_we = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic busy, irq_done;
    logic desc_req, desc_ack = 0; logic [31:0] desc_addr, desc_rdata = 0;
    logic src_req, src_ack = 0, src_err = 0; logic [31:0] src_addr, src_rdata = 0;
    logic dst_req, dst_ack = 0, dst_err = 0; logic [31:0] dst_addr, dst_wdata;

    int total = 0, bad = 0;
    int nwr = 0, nirq = 0, bad_data = 0, ndesc = 0, desc_bad = 0;
    logic [31:0] err_src = 32'hFFFF_FFFF, err_dst = 32'hFFFF_FFFF;
    logic [31:0] dmem [64];

    sg_copy_engine dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    always @(negedge clk) begin
        if (irq_done) nirq++;
        if (desc_req && !desc_ack) begin
            desc_ack = 1; desc_rdata = dmem[desc_addr[7:2]];
            if (desc_addr != DBASE + 32'(4 * ndesc)) desc_bad++;
            ndesc++;
        end else desc_ack = 0;
        if (src_req && !src_ack) begin
            src_ack = 1; src_rdata = pat(src_addr); src_err = (src_addr == err_src);
        end else begin src_ack = 0; src_err = 0; end
        if (dst_req && !dst_ack) begin
            dst_ack = 1; dst_err = (dst_addr == err_dst);
            if (!dst_err) begin
                nwr++;
                if (dst_wdata != pat(dst_addr - 32'h7000)) bad_data++;
            end
        end else begin dst_ack = 0; dst_err = 0; end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic read_stat(output logic [31:0] v);
        @(negedge clk); reg_addr = 4'h4; #1 v = reg_rdata;
    endtask

    task automatic load(input logic [17:0] c0, input logic [17:0] c1, input bit two,
                        input logic [12:0] rsv);
        dmem[16] = 32'h1000; dmem[17] = 32'h8000; dmem[18] = {~two, rsv, c0};
        dmem[19] = 32'h2000; dmem[20] = 32'h9000; dmem[21] = {1'b1, rsv, c1};
        nwr = 0; nirq = 0; bad_data = 0; ndesc = 0; desc_bad = 0;
    endtask

    task automatic kick(input int extra_start_after);
        reg_write(4'h0, DBASE);
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        if (extra_start_after > 0) begin
            repeat (extra_start_after) @(negedge clk);
            start = 1; @(negedge clk); start = 0;
        end
        for (int i = 0; i < 20000 && nirq == 0; i++) @(negedge clk);
        if (nirq == 0) check("R5 irq timeout", 0, 1);
        repeat (60) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] s;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 requests", {29'd0, desc_req, src_req, dst_req}, 0);
        check("R11 irq/busy", {30'd0, irq_done, busy}, 0);
        rst_n = 1;
        read_stat(s); check("R11 status", s, 0);

        for (int t = 0; t < NT; t++) begin
            load(T_C0[t], T_C1[t], T_TWO[t], 13'd0);
            kick(0);
            read_stat(s); check("R3/R6 status", s, 32'(T_ST[t]));
            check("R4/R5 write count", nwr, T_WR[t]);
            check("R4 data", bad_data, 0);
            check("R1 fetch order", desc_bad, 0);
            check("R5 single irq", nirq, 1);
            reg_write(4'h4, 32'h1F);
            read_stat(s); check("R9 clear", s, 0);
        end

        // R2: reserved bits set have no effect
        load(18'd512, 18'd0, 1'b0, 13'h1FFF);
        kick(0);
        read_stat(s); check("R2 reserved status", s, 32'h03);
        check("R2 reserved writes", nwr, 128);
        reg_write(4'h4, 32'h1F);

        // R10: start during busy ignored
        load(18'd256, 18'd512, 1'b1, 13'd0);
        kick(30);
        check("R10 irq count", nirq, 1);
        check("R10 writes", nwr, 192);
        check("R10 fetches", ndesc, 6);
        check("R10 idle", {31'd0, busy}, 0);

        // R9: partial clear leaves other bits
        reg_write(4'h4, 32'h01);
        read_stat(s); check("R9 partial clear", s, 32'h02);
        reg_write(4'h4, 32'h1F);

        // R7: source error
        err_src = 32'h1040;
        load(18'd256, 18'd0, 1'b0, 13'd0);
        kick(0);
        read_stat(s); check("R7 status", s, 32'h04);
        check("R7 writes", nwr, 16);
        err_src = 32'hFFFF_FFFF;
        reg_write(4'h4, 32'h1F);

        // R8: destination error aborts remaining elements
        err_dst = 32'h8080;
        load(18'd256, 18'd256, 1'b1, 13'd0);
        kick(0);
        read_stat(s); check("R8 status", s, 32'h08);
        check("R8 writes", nwr, 32);
        check("R8 fetches", ndesc, 3);
        err_dst = 32'hFFFF_FFFF;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule